// File: doc/BRIEF.md
# I2C master command sequencer

This block sits between a queue of master command words and a byte-level I2C bus engine. It pops one command at a time. For each command it works out which bus conditions must come before the byte and which must come after it. It then issues a series of single-operation requests to the engine: START, repeated START, STOP, write-byte and read-byte. Bit timing, arbitration and the register bus are handled elsewhere.

Each command word carries a data byte, a direction bit, a stop-after flag and a restart-before flag. The `restart_en_i` input chooses how a change of transfer is made. When it is high, a repeated START is used. When it is low, the block closes the transfer with a STOP and opens a new one with START. Every START or repeated START is followed by an address byte built from `tgt_addr_i` and the direction of the command. If the queue runs dry while a transfer is open and no STOP was asked for, the block raises `scl_hold_o` to keep the clock low until the next command arrives. Received bytes are returned with a flag that marks the first byte after an address phase.

Top module: `i2cm_cmd_seq`

## Requirements
- R1: Command word layout: bits [7:0] hold the data, bit 8 the direction (1 = read), bit 9 the stop-after flag and bit 10 the restart-before flag. Engine operation codes on `eng_op_o` are 1 = START, 2 = repeated START, 3 = STOP, 4 = write-byte and 5 = read-byte. The address byte is `{tgt_addr_i, direction}` and is sent as a write-byte.
- R2: A command taken while no transfer is open, whether from idle or after a STOP, produces START, then the address byte, then the command's own byte operation.
- R3: With `restart_en_i` = 1 and restart-before set, a repeated START and an address byte come before the byte, even when the direction is unchanged.
- R4: With `restart_en_i` = 1 and restart-before clear, a repeated START and address are issued only if the direction differs from the previous command. Otherwise the byte operation follows directly.
- R5: With `restart_en_i` = 0, every case that would issue a repeated START issues STOP, START and the address byte instead.
- R6: With stop-after set, a STOP follows the byte. If more commands are queued, the next one then begins with a fresh START.
- R7: With stop-after clear and the queue empty after the byte, `scl_hold_o` is 1 and no engine request is made until a command arrives. That command then continues the open transfer.
- R8: A read-byte request drives `eng_byte_o` to 0 whatever the data field holds. `eng_ack_o` is 1 (ACK) unless stop-after is set, in which case it is 0 (NACK).
- R9: Each completed read-byte produces a one-cycle `rx_valid_o` in the cycle after `eng_done_i`, carrying `eng_rdata_i`. `rx_first_o` is 1 for the first byte after an address phase and 0 for later bytes.
- R10: A command is popped only from idle or stall with a command available, or in the cycle the engine completes a byte or the trailing STOP. Every queued command is popped exactly once.
- R11: After reset the block is idle: no engine request, no stall, no pop and no receive strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_en_i | input | 1 | 1: use repeated START; 0: use STOP then START |
| tgt_addr_i | input | 7 | Target address for address phases |
| cmd_valid_i | input | 1 | Command queue not empty |
| cmd_word_i | input | 11 | Command at the head of the queue |
| cmd_pop_o | output | 1 | Remove head command this cycle |
| eng_req_o | output | 1 | Engine operation requested |
| eng_op_o | output | 3 | Requested operation code |
| eng_byte_o | output | 8 | Byte to transmit |
| eng_ack_o | output | 1 | ACK (1) or NACK (0) after a read byte |
| eng_done_i | input | 1 | Engine finished the current operation |
| eng_rdata_i | input | 8 | Byte received by the engine |
| scl_hold_o | output | 1 | Stall: hold the clock low |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| rx_first_o | output | 1 | Byte is the first after an address phase |

## Verification
The bench builds the block with the package defaults: 8-bit data, a 7-bit target address and an 11-bit command word. With these widths, address bytes 0x54 and 0x55 can be checked exactly for target 0x2A.

The bench's engine model completes every operation two cycles after the request. Its queue model holds up to 32 words. This puts pops that land on a done cycle, stalls with the queue empty, and strings of back-to-back transfers within reach. Both settings of the restart enable are run against direction changes and forced restarts.

// File: rtl/i2cm_seq_pkg.sv
package i2cm_seq_pkg;

    parameter int unsigned DATA_W = 8;
    parameter int unsigned ADDR_W = 7;
    localparam int unsigned CMD_W  = DATA_W + 3;
    localparam int unsigned OP_W   = 3;

    // Command word, most significant field first.
    typedef struct packed {
        logic              restart;
        logic              stop;
        logic              rd;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_STOP   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_READ   = 3'd5
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_STOP_PRE,
        ST_START,
        ST_RSTART,
        ST_ADDR,
        ST_DATA,
        ST_STOP_POST
    } seq_state_e;

    // First step for a freshly fetched command.
    function automatic seq_state_e entry_step(
        input logic restart,
        input logic rd,
        input logic open,
        input logic prev_rd,
        input logic rs_en
    );
        if (!open) return ST_START;
        if (restart || (rd != prev_rd)) return rs_en ? ST_RSTART : ST_STOP_PRE;
        return ST_DATA;
    endfunction

    function automatic logic is_bus_step(input seq_state_e s);
        return !(s == ST_IDLE || s == ST_HOLD);
    endfunction

endpackage

// File: rtl/i2cm_cond_decide.sv
module i2cm_cond_decide
    import i2cm_seq_pkg::*;
(
    input  logic       restart_i,
    input  logic       rd_i,
    input  logic       open_i,
    input  logic       prev_rd_i,
    input  logic       rs_en_i,
    output seq_state_e entry_o
);
    always_comb begin
        entry_o = entry_step(restart_i, rd_i, open_i, prev_rd_i, rs_en_i);
    end
endmodule

// File: rtl/i2cm_seq_fsm.sv
module i2cm_seq_fsm
    import i2cm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid_i,
    input  cmd_t       cmd_i,
    input  logic       eng_done_i,
    input  seq_state_e entry_i,
    output logic       pop_o,
    output logic       open_o,
    output logic       prev_rd_o,
    output seq_state_e state_o,
    output cmd_t       cur_o
);
    seq_state_e st_q, st_d;
    cmd_t       cur_q;
    logic       byte_done, tail_stop_done, may_fetch;

    assign byte_done      = (st_q == ST_DATA) && eng_done_i;
    assign tail_stop_done = (st_q == ST_STOP_POST) && eng_done_i;
    assign may_fetch      = (st_q == ST_IDLE) || (st_q == ST_HOLD)
                          || (byte_done && !cur_q.stop) || tail_stop_done;

    assign pop_o     = cmd_valid_i && may_fetch;
    // A transfer is open while a byte has just run or the bus is stalled.
    assign open_o    = (st_q == ST_HOLD) || (st_q == ST_DATA);
    assign prev_rd_o = cur_q.rd;
    assign state_o   = st_q;
    assign cur_o     = cur_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_HOLD: if (cmd_valid_i) st_d = entry_i;
            ST_STOP_PRE:      if (eng_done_i) st_d = ST_START;
            ST_START,
            ST_RSTART:        if (eng_done_i) st_d = ST_ADDR;
            ST_ADDR:          if (eng_done_i) st_d = ST_DATA;
            ST_DATA: begin
                if (eng_done_i) begin
                    if (cur_q.stop)       st_d = ST_STOP_POST;
                    else if (cmd_valid_i) st_d = entry_i;
                    else                  st_d = ST_HOLD;
                end
            end
            ST_STOP_POST: if (eng_done_i) st_d = cmd_valid_i ? entry_i : ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cur_q <= '0;
        end else begin
            st_q <= st_d;
            if (pop_o) cur_q <= cmd_i;
        end
    end

    // R10: a fetched command always starts bus activity next cycle
    assert_pop_starts_R10: assert property (@(posedge clk) disable iff (rst)
        pop_o |=> is_bus_step(st_q));

    // R6: a stop-after byte is followed by the trailing STOP step
    assert_stop_after_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && eng_done_i && cur_q.stop) |=> (st_q == ST_STOP_POST));

    // R7: an open transfer with an empty queue stalls
    assert_stall_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && eng_done_i && !cur_q.stop && !cmd_valid_i) |=> (st_q == ST_HOLD));
endmodule

// File: rtl/i2cm_op_drive.sv
module i2cm_op_drive
    import i2cm_seq_pkg::*;
(
    input  seq_state_e        state_i,
    input  cmd_t              cur_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    output logic              req_o,
    output bus_op_e           op_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              ack_o
);
    always_comb begin
        req_o  = is_bus_step(state_i);
        op_o   = OP_NONE;
        byte_o = '0;
        ack_o  = 1'b0;
        unique case (state_i)
            ST_STOP_PRE,
            ST_STOP_POST: op_o = OP_STOP;
            ST_START:     op_o = OP_START;
            ST_RSTART:    op_o = OP_RSTART;
            ST_ADDR: begin
                op_o   = OP_WRITE;
                byte_o = DATA_W'({tgt_addr_i, cur_i.rd});
            end
            ST_DATA: begin
                if (cur_i.rd) begin
                    op_o  = OP_READ;
                    ack_o = !cur_i.stop;
                end else begin
                    op_o   = OP_WRITE;
                    byte_o = cur_i.data;
                end
            end
            default: op_o = OP_NONE;
        endcase
    end
endmodule

// File: rtl/i2cm_rx_tag.sv
module i2cm_rx_tag
    import i2cm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_i,
    input  logic              cur_rd_i,
    input  logic              eng_done_i,
    input  logic [DATA_W-1:0] eng_rdata_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_first_o
);
    logic first_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pend_q <= 1'b0;
            rx_valid_o   <= 1'b0;
            rx_data_o    <= '0;
            rx_first_o   <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (state_i == ST_ADDR && eng_done_i) first_pend_q <= 1'b1;
            if (state_i == ST_DATA && eng_done_i && cur_rd_i) begin
                rx_valid_o   <= 1'b1;
                rx_data_o    <= eng_rdata_i;
                rx_first_o   <= first_pend_q;
                first_pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cm_cmd_seq.sv
module i2cm_cmd_seq
    import i2cm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_en_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic              cmd_valid_i,
    input  logic [CMD_W-1:0]  cmd_word_i,
    output logic              cmd_pop_o,
    output logic              eng_req_o,
    output logic [OP_W-1:0]   eng_op_o,
    output logic [DATA_W-1:0] eng_byte_o,
    output logic              eng_ack_o,
    input  logic              eng_done_i,
    input  logic [DATA_W-1:0] eng_rdata_i,
    output logic              scl_hold_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_first_o
);
    cmd_t       cmd_in, cur;
    seq_state_e entry, state;
    logic       open, prev_rd;
    bus_op_e    op;

    assign cmd_in = cmd_t'(cmd_word_i);

    i2cm_cond_decide u_decide (
        .restart_i (cmd_in.restart),
        .rd_i      (cmd_in.rd),
        .open_i    (open),
        .prev_rd_i (prev_rd),
        .rs_en_i   (restart_en_i),
        .entry_o   (entry)
    );

    i2cm_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_in),
        .eng_done_i  (eng_done_i),
        .entry_i     (entry),
        .pop_o       (cmd_pop_o),
        .open_o      (open),
        .prev_rd_o   (prev_rd),
        .state_o     (state),
        .cur_o       (cur)
    );

    i2cm_op_drive u_drive (
        .state_i    (state),
        .cur_i      (cur),
        .tgt_addr_i (tgt_addr_i),
        .req_o      (eng_req_o),
        .op_o       (op),
        .byte_o     (eng_byte_o),
        .ack_o      (eng_ack_o)
    );

    i2cm_rx_tag u_rx (
        .clk         (clk),
        .rst         (rst),
        .state_i     (state),
        .cur_rd_i    (cur.rd),
        .eng_done_i  (eng_done_i),
        .eng_rdata_i (eng_rdata_i),
        .rx_valid_o  (rx_valid_o),
        .rx_data_o   (rx_data_o),
        .rx_first_o  (rx_first_o)
    );

    assign eng_op_o   = op;
    assign scl_hold_o = (state == ST_HOLD);

    // R7: no bus request while the clock is held
    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        scl_hold_o |-> !eng_req_o);

    // R8: read requests never carry command data
    assert_read_blank_R8: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && eng_op_o == OP_READ) |-> (eng_byte_o == '0));

    // R2: an address write follows every START or repeated START
    assert_addr_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && eng_done_i && (eng_op_o == OP_START || eng_op_o == OP_RSTART))
        |=> (eng_req_o && eng_op_o == OP_WRITE));

    // R9: receive strobe only after a completed read
    assert_rx_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(eng_done_i && eng_op_o == OP_READ));
endmodule

// File: tb/test_i2cm_cmd_seq.sv
`timescale 1ns/100ps
module test_i2cm_cmd_seq;
    import i2cm_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              restart_en = 1'b1;
    logic [ADDR_W-1:0] tgt = 7'h2A;
    logic              cmd_valid = 1'b0;
    logic [CMD_W-1:0]  cmd_word = '0;
    logic              cmd_pop;
    logic              eng_req;
    logic [OP_W-1:0]   eng_op;
    logic [DATA_W-1:0] eng_byte;
    logic              eng_ack;
    logic              eng_done = 1'b0;
    logic [DATA_W-1:0] eng_rdata = '0;
    logic              scl_hold;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              rx_first;

    always #2 clk = ~clk;

    i2cm_cmd_seq i_i2cm_cmd_seq (
        .clk(clk), .rst(rst), .restart_en_i(restart_en), .tgt_addr_i(tgt),
        .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word), .cmd_pop_o(cmd_pop),
        .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_byte_o(eng_byte),
        .eng_ack_o(eng_ack), .eng_done_i(eng_done), .eng_rdata_i(eng_rdata),
        .scl_hold_o(scl_hold), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rx_first_o(rx_first)
    );

    int n_chk = 0, n_bad = 0;

    // queue model
    logic [CMD_W-1:0] q [0:31];
    int q_head = 0, q_tail = 0;
    logic pop_pend = 1'b0;

    // observation logs
    int lg_op [0:63];
    int lg_n = 0;
    int ex_op [0:63];
    int ex_n = 0;
    int rx_log [0:15];
    int rx_n = 0;
    int rx_ex [0:15];
    int rx_en = 0;
    int rd_seq = 0;
    int bad_pop = 0;
    int hold_req = 0;

    localparam int OP_LAT = 2;

    // engine and queue model, acting at the falling edge
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (pop_pend) begin
                q_head++;
                pop_pend = 1'b0;
            end
            cmd_valid = (q_head != q_tail);
            cmd_word  = q[q_head % 32];
            eng_done  = 1'b0;
            if (!rst && eng_req) begin
                cnt++;
                if (cnt >= OP_LAT) begin
                    eng_done = 1'b1;
                    cnt = 0;
                    if (lg_n < 64) lg_op[lg_n] = {eng_op, eng_byte, eng_ack};
                    lg_n++;
                    if (eng_op == 3'd5) begin
                        eng_rdata = 8'hC0 + 8'(rd_seq);
                        rd_seq++;
                    end
                end
            end else begin
                cnt = 0;
            end
            #1;
            if (!rst) begin
                pop_pend = cmd_pop;
                if (cmd_pop && eng_req && !eng_done) bad_pop++;
                if (scl_hold && eng_req) hold_req++;
                if (rx_valid) begin
                    if (rx_n < 16) rx_log[rx_n] = {rx_data, rx_first};
                    rx_n++;
                end
            end
        end
    end

    function automatic logic [CMD_W-1:0] mk(input logic rs, input logic sp,
                                             input logic rd, input logic [7:0] d);
        return {rs, sp, rd, d};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ex(input int op, input int b, input int a);
        ex_op[ex_n] = (op << 9) | (b << 1) | a;
        ex_n++;
    endtask

    task automatic ex_rx(input int d, input int f);
        rx_ex[rx_en] = (d << 1) | f;
        rx_en++;
    endtask

    task automatic push(input logic [CMD_W-1:0] w);
        q[q_tail % 32] = w;
        q_tail++;
    endtask

    task automatic do_reset();
        @(posedge clk); #0.5;
        rst = 1'b1;
        q_head = 0; q_tail = 0;
        lg_n = 0; ex_n = 0; rx_n = 0; rx_en = 0; rd_seq = 0;
        bad_pop = 0; hold_req = 0;
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
    endtask

    task automatic run_idle();
        int quiet;
        quiet = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #0.5;
            if (q_head == q_tail && !eng_req && !pop_pend) quiet++;
            else quiet = 0;
            if (quiet >= 4) break;
        end
    endtask

    task automatic chk_log(input string req);
        chk(req, "operation count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++)
            chk(req, $sformatf("operation %0d {op,byte,ack}", i), lg_op[i], ex_op[i]);
        chk(req, "receive count", rx_n, rx_en);
        for (int i = 0; i < rx_en && i < rx_n; i++)
            chk(req, $sformatf("receive %0d {data,first}", i), rx_log[i], rx_ex[i]);
        chk("R10", "queue drained", q_tail - q_head, 0);
        chk("R10", "pops during busy step", bad_pop, 0);
    endtask

    task automatic t_reset();
        @(posedge clk); #0.5;
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R11", "req in reset", int'(eng_req), 0);
        chk("R11", "hold in reset", int'(scl_hold), 0);
        chk("R11", "pop in reset", int'(cmd_pop), 0);
        chk("R11", "rx strobe in reset", int'(rx_valid), 0);
        do_reset();
        repeat (5) @(posedge clk);
        #1;
        chk("R11", "req after reset", int'(eng_req), 0);
        chk("R11", "hold after reset", int'(scl_hold), 0);
    endtask

    task automatic t_single_write();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 1, 0, 8'hA5));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'hA5, 0); ex(3, 0, 0);
        run_idle();
        chk_log("R2 R1 R6");
        chk("R6", "hold after stop", int'(scl_hold), 0);
    endtask

    task automatic t_stall();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 0, 0, 8'h11));
        push(mk(0, 0, 0, 8'h22));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h11, 0); ex(4, 8'h22, 0);
        run_idle();
        repeat (20) @(posedge clk);
        #0.5;
        chk("R7", "hold while empty", int'(scl_hold), 1);
        chk("R7", "ops while stalled", lg_n, 4);
        chk("R7", "req during hold", hold_req, 0);
        push(mk(0, 1, 0, 8'h33));
        ex(4, 8'h33, 0); ex(3, 0, 0);
        run_idle();
        chk_log("R7 R4");
        chk("R7", "hold released", int'(scl_hold), 0);
    endtask

    task automatic t_dir_restart();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 0, 0, 8'h10));
        push(mk(0, 1, 1, 8'h5A));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h10, 0);
        ex(2, 0, 0); ex(4, 8'h55, 0); ex(5, 0, 0); ex(3, 0, 0);
        ex_rx(8'hC0, 1);
        run_idle();
        chk_log("R4 R8 R9");
    endtask

    task automatic t_same_restart();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 0, 0, 8'h01));
        push(mk(1, 1, 0, 8'h02));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h01, 0);
        ex(2, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h02, 0); ex(3, 0, 0);
        run_idle();
        chk_log("R3");
    endtask

    task automatic t_no_rs_en();
        do_reset();
        restart_en = 1'b0;
        push(mk(0, 0, 0, 8'h10));
        push(mk(0, 1, 1, 8'h77));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h10, 0);
        ex(3, 0, 0); ex(1, 0, 0); ex(4, 8'h55, 0); ex(5, 0, 0); ex(3, 0, 0);
        ex_rx(8'hC0, 1);
        run_idle();
        push(mk(0, 0, 0, 8'h01));
        push(mk(1, 1, 0, 8'h02));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h01, 0);
        ex(3, 0, 0); ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h02, 0); ex(3, 0, 0);
        run_idle();
        chk_log("R5");
        restart_en = 1'b1;
    endtask

    task automatic t_reads();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 0, 1, 8'hFF));
        push(mk(0, 0, 1, 8'h3C));
        push(mk(0, 1, 1, 8'hA5));
        ex(1, 0, 0); ex(4, 8'h55, 0);
        ex(5, 0, 1); ex(5, 0, 1); ex(5, 0, 0); ex(3, 0, 0);
        ex_rx(8'hC0, 1); ex_rx(8'hC1, 0); ex_rx(8'hC2, 0);
        run_idle();
        chk_log("R8 R9 R4");
    endtask

    task automatic t_back_to_back();
        do_reset();
        restart_en = 1'b1;
        push(mk(0, 1, 0, 8'h41));
        push(mk(0, 1, 0, 8'h42));
        push(mk(0, 1, 1, 8'h00));
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h41, 0); ex(3, 0, 0);
        ex(1, 0, 0); ex(4, 8'h54, 0); ex(4, 8'h42, 0); ex(3, 0, 0);
        ex(1, 0, 0); ex(4, 8'h55, 0); ex(5, 0, 0); ex(3, 0, 0);
        ex_rx(8'hC0, 1);
        run_idle();
        chk_log("R6 R10 R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single_write();
        t_stall();
        t_dir_restart();
        t_same_restart();
        t_no_rs_en();
        t_reads();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule